// File: doc/BRIEF.md
# Switch Management Bus Byte Access Master

This block is a master for a two-wire management bus (a clock output plus a bidirectional data line). It reads and writes the byte-wide registers of a small Ethernet switch. Each frame looks like a clause-22 management frame with three differences. The opcode is always 00. The read/write choice travels in the top bit of the PHY address field. The eight-bit register address is split so that its upper three bits go into the PHY address field and its lower five bits into the REG address field. Only the low byte of the sixteen-bit data field carries the register value.

The host hands over one request: a start register address, a write flag, a size code and up to four bytes of write data. The block runs one single-byte frame for each byte, at consecutive register addresses. The byte at the lowest address is the most significant byte of the host-side value. When the last frame ends, the block pulses `done` and presents the assembled read value, right-aligned. The request side is valid/ready. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a transfer runs, `req_valid` is ignored and must be held by the host. The response side has no back-pressure: `rd_data` is valid in the cycle `done` is high and holds its value until the next response.

Top module: `smi_byte_master`

## Requirements
- R1: After reset, `req_ready` is 1, `mdio_oe` is 0 and `done` is 0.
- R2: Every frame is 64 bit times long. Its first 32 bits are 1s, then the start pattern 0,1, then the opcode 0,0. Bits go onto the line most significant first.
- R3: After the opcode comes a 5-bit PHY field: read flag (1 = read), then 0, then register address bits 7:5. Then comes a 5-bit REG field holding register address bits 4:0.
- R4: In a write frame, the turnaround bits are 1 then 0 and `mdio_oe` stays high for all 64 bits. The data field is eight 0s followed by the register byte, and the target stores that byte.
- R5: In a read frame, `mdio_oe` is low during the two turnaround bits and the sixteen data bits. The register byte is taken from the last eight data bits, sampled on rising clock edges.
- R6: Size code 0 gives 1 frame, 1 gives 2 frames, and 2 or 3 gives 4 frames. The frames use consecutive register addresses from the start address, wrapping modulo 256, and the PHY/REG split is recomputed for each frame.
- R7: Multi-byte order is big-endian. The write byte sent to the lowest address is the most significant of the used bytes of `req_wdata` (its low 8, 16 or 32 bits). A read returns the byte from the lowest address most significant in `rd_data`, right-aligned with zeros above.
- R8: `req_ready` is low from the cycle after a request is accepted until the transfer completes. Any `req_valid` seen during that time starts no frame and changes no register.
- R9: `done` is high for exactly one clock per request, after the last frame. At that point the data line is released (`mdio_oe` low).
- R10: `mdc` has a period of CLK_DIV system clocks with equal high and low halves. `mdio_o` changes only in the clock cycle in which `mdc` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | First register address |
| req_size | input | 2 | Byte count code: 0 = 1, 1 = 2, 2 or 3 = 4 |
| req_wdata | input | 32 | Write value, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Read value, right-aligned, valid with done |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The test requests come from a table that covers one-, two- and four-byte reads and writes. Some requests start just below a 32-byte boundary, so the PHY field changes in the middle of a burst. One starts at 0xFE, so the address wraps to 0x00. Writes carry junk in the unused upper bytes, and a later read of the same range shows whether the byte order and the ignoring of those bytes are correct. A bus target model in the bench decodes every frame field by field. Directed cases add the reset state, a request held during a busy transfer, the length of the done pulse, and the clock period and the edge on which data changes.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int RX_FIRST   = 56;

  typedef enum logic [1:0] {ENG_IDLE, ENG_WAIT, ENG_SHIFT} eng_state_t;
  typedef enum logic {CTL_IDLE, CTL_RUN} ctl_state_t;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/smi_clkgen.sv
module smi_clkgen #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_evt,
  output logic fall_evt
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  generate
    if (HALF > 1) begin : g_count
      assign wrap = (cnt == LAST);
    end else begin : g_every
      assign wrap = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign rise_evt = wrap && !mdc;
  assign fall_evt = wrap &&  mdc;
endmodule

// File: rtl/smi_frame_engine.sv
module smi_frame_engine
  import smi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mdc,
  input  logic       rise_evt,
  input  logic       fall_evt,
  input  logic       start,
  input  logic [7:0] st_addr,
  input  logic       st_write,
  input  logic [7:0] st_byte,
  input  logic       mdio_i,
  output logic       mdio_o,
  output logic       mdio_oe,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       idle
);
  localparam logic [5:0] LAST_BIT = 6'(FRAME_BITS - 1);
  localparam logic [5:0] TA_BIT   = 6'(TA_FIRST);
  localparam logic [5:0] RX_BIT   = 6'(RX_FIRST);

  eng_state_t state;
  logic [5:0] bitcnt;
  logic [5:0] nxt;
  logic [7:0] addr_q;
  logic [7:0] byte_q;
  logic       wr_q;
  logic [FRAME_BITS-1:0] frame_vec;

  // layout: preamble, start, opcode, PHY field, REG field, turnaround, data
  always_comb begin
    frame_vec = {32'hFFFF_FFFF, 2'b01, 2'b00,
                 ~wr_q, 1'b0, addr_q[7:5], addr_q[4:0],
                 (wr_q ? 2'b10 : 2'b00),
                 8'h00, (wr_q ? byte_q : 8'h00)};
  end

  assign nxt  = bitcnt + 6'd1;
  assign idle = (state == ENG_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ENG_IDLE;
      bitcnt    <= '0;
      addr_q    <= '0;
      byte_q    <= '0;
      wr_q      <= 1'b0;
      rx_byte   <= '0;
      mdio_o    <= 1'b0;
      mdio_oe   <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      case (state)
        ENG_IDLE: begin
          if (start) begin
            addr_q  <= st_addr;
            byte_q  <= st_byte;
            wr_q    <= st_write;
            rx_byte <= '0;
            state   <= ENG_WAIT;
          end
        end
        ENG_WAIT: begin
          if (fall_evt) begin
            bitcnt  <= '0;
            mdio_o  <= frame_vec[LAST_BIT];
            mdio_oe <= 1'b1;
            state   <= ENG_SHIFT;
          end
        end
        default: begin
          if (rise_evt && !wr_q && bitcnt >= RX_BIT)
            rx_byte <= {rx_byte[6:0], mdio_i};
          if (fall_evt) begin
            if (bitcnt == LAST_BIT) begin
              mdio_o    <= 1'b0;
              mdio_oe   <= 1'b0;
              byte_done <= 1'b1;
              state     <= ENG_IDLE;
            end else begin
              bitcnt  <= nxt;
              mdio_o  <= frame_vec[LAST_BIT - nxt];
              mdio_oe <= wr_q || (nxt < TA_BIT);
            end
          end
        end
      endcase
    end
  end

  assert_drive_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));

  assert_read_tail_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SHIFT && !wr_q && bitcnt >= TA_BIT) |-> !mdio_oe);

  assert_write_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ENG_SHIFT && wr_q) |-> mdio_oe);

  assert_line_free_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> !mdio_oe);
endmodule

// File: rtl/smi_byte_master.sv
module smi_byte_master
  import smi_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [7:0]  req_addr,
  input  logic [1:0]  req_size,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  ctl_state_t  state;
  logic [2:0]  remaining;
  logic [7:0]  addr_q;
  logic        wr_q;
  logic [31:0] wshift;
  logic [31:0] acc;
  logic [31:0] acc_n;
  logic [2:0]  nbytes;
  logic        eng_start;
  logic        eng_idle;
  logic        byte_done;
  logic [7:0]  rx_byte;
  logic        rise_evt;
  logic        fall_evt;

  smi_clkgen #(.CLK_DIV(CLK_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  smi_frame_engine u_eng (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt),
    .start(eng_start), .st_addr(addr_q), .st_write(wr_q), .st_byte(wshift[31:24]),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .byte_done(byte_done), .rx_byte(rx_byte), .idle(eng_idle)
  );

  assign req_ready = (state == CTL_IDLE);
  assign nbytes    = size_to_bytes(req_size);
  assign acc_n     = {acc[23:0], rx_byte};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CTL_IDLE;
      remaining <= '0;
      addr_q    <= '0;
      wr_q      <= 1'b0;
      wshift    <= '0;
      acc       <= '0;
      eng_start <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done      <= 1'b0;
      eng_start <= 1'b0;
      case (state)
        CTL_IDLE: begin
          if (req_valid) begin
            addr_q    <= req_addr;
            wr_q      <= req_write;
            remaining <= nbytes;
            acc       <= '0;
            wshift    <= req_wdata << (6'd8 * (6'd4 - 6'(nbytes)));
            eng_start <= 1'b1;
            state     <= CTL_RUN;
          end
        end
        default: begin
          if (byte_done) begin
            if (remaining == 3'd1) begin
              rd_data <= acc_n;
              done    <= 1'b1;
              state   <= CTL_IDLE;
            end else begin
              acc       <= acc_n;
              remaining <= remaining - 3'd1;
              addr_q    <= addr_q + 8'd1;
              wshift    <= {wshift[23:0], 8'h00};
              eng_start <= 1'b1;
            end
          end
        end
      endcase
    end
  end

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_busy_after_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_start_into_idle_engine_R6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> eng_idle);

  assert_count_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == CTL_RUN) |-> (remaining != 3'd0));
endmodule

// File: tb/tb_smi_byte_master.sv
module tb_smi_byte_master;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, mdc, mdio_o, mdio_oe, mdio_i;
  logic [31:0] rd_data;
  logic        tgt_en = 1'b0, tgt_val = 1'b0;

  assign mdio_i = mdio_oe ? mdio_o : (tgt_en ? tgt_val : 1'b1);

  smi_byte_master #(.CLK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_chk = 0, n_bad = 0;
  bit summary_done = 1'b0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_byte(input int a);
    return 8'(a * 37 + 11);
  endfunction

  // ---------------- target model ----------------
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  logic [7:0]  fr_addr [16];
  logic        fr_rd [16];
  int          total_frames = 0;
  int          pos = 0;
  bit          inframe = 1'b0, is_read = 1'b0;
  logic [63:0] sh = '0;
  logic [7:0]  cur_addr = '0;
  int err_hdr = 0, err_phy = 0, err_wr = 0, err_rd = 0, err_edge = 0;

  always @(posedge mdc) begin
    if (!inframe && mdio_oe) begin
      inframe = 1'b1;
      pos = 0;
    end
    if (inframe) begin
      if (pos < 46 && !mdio_oe) err_hdr++;
      if (pos >= 46 && is_read && mdio_oe) err_rd++;
      if (pos >= 46 && !is_read && !mdio_oe) err_wr++;
      sh = {sh[62:0], mdio_i};
      if (pos == 36) is_read = mdio_i;
      if (pos == 45) cur_addr = {sh[7:5], sh[4:0]};
      pos++;
      if (pos == 64) begin
        if (sh[63:32] != 32'hFFFF_FFFF || sh[31:30] != 2'b01 || sh[29:28] != 2'b00) err_hdr++;
        if (sh[26] != 1'b0) err_phy++;
        if (!is_read) begin
          if (sh[17:16] != 2'b10 || sh[15:8] != 8'h00) err_wr++;
          mem[cur_addr] = sh[7:0];
        end
        fr_addr[total_frames % 16] = cur_addr;
        fr_rd[total_frames % 16]   = is_read;
        total_frames++;
        inframe = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (inframe && is_read && pos >= 47 && pos <= 63) begin
      tgt_en  = 1'b1;
      tgt_val = (pos < 56) ? 1'b0 : mem[cur_addr][63 - pos];
    end else begin
      tgt_en = 1'b0;
    end
  end

  // R10: data line changes only in the cycle mdc falls
  logic prev_o = 1'b0, prev_mdc = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (mdio_o !== prev_o) && !(prev_mdc === 1'b1 && mdc === 1'b0)) err_edge++;
    prev_o   = mdio_o;
    prev_mdc = mdc;
  end

  // ---------------- request task ----------------
  task automatic do_req(input logic wr, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    bit ok;
    @(negedge clk);
    chk("R8", "ready before request", {31'b0, req_ready}, 32'd1);
    req_write = wr; req_size = sz; req_addr = a; req_wdata = wd; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    ok = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    rd = rd_data;
    chk("R9", "done seen", {31'b0, ok}, 32'd1);
    chk("R9", "line released at done", {31'b0, mdio_oe}, 32'd0);
    @(negedge clk);
    chk("R9", "done one cycle", {31'b0, done}, 32'd0);
  endtask

  localparam logic [42:0] VEC [13] = '{
    {1'b0, 2'd0, 8'h00, 32'h0000_0000},
    {1'b0, 2'd1, 8'h10, 32'h0000_0000},
    {1'b0, 2'd2, 8'h1E, 32'h0000_0000},
    {1'b1, 2'd0, 8'hE3, 32'hFFFF_FFA5},
    {1'b0, 2'd0, 8'hE3, 32'h0000_0000},
    {1'b1, 2'd1, 8'h3F, 32'h0000_1234},
    {1'b0, 2'd1, 8'h3F, 32'h0000_0000},
    {1'b1, 2'd2, 8'h80, 32'hDEAD_BEEF},
    {1'b0, 2'd3, 8'h80, 32'h0000_0000},
    {1'b0, 2'd0, 8'hFF, 32'h0000_0000},
    {1'b0, 2'd2, 8'hFE, 32'h0000_0000},
    {1'b1, 2'd1, 8'h7F, 32'hFFFF_C35A},
    {1'b0, 2'd2, 8'h7E, 32'h0000_0000}
  };

  task automatic finish_run();
    if (!summary_done) begin
      summary_done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd, expv;
    for (int a = 0; a < 256; a++) begin
      mem[a] = init_byte(a);
      shadow[a] = init_byte(a);
    end
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "oe in reset", {31'b0, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "ready after reset", {31'b0, req_ready}, 32'd1);
    chk("R1", "oe after reset", {31'b0, mdio_oe}, 32'd0);
    chk("R1", "done after reset", {31'b0, done}, 32'd0);

    for (int i = 0; i < 13; i++) begin
      logic wr; logic [1:0] sz; logic [7:0] a; logic [31:0] wd;
      int nb, base;
      {wr, sz, a, wd} = VEC[i];
      nb = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
      expv = '0;
      for (int k = 0; k < nb; k++) begin
        if (wr) shadow[8'(a + k)] = 8'(wd >> (8 * (nb - 1 - k)));
        expv = {expv[23:0], shadow[8'(a + k)]};
      end
      base = total_frames;
      do_req(wr, sz, a, wd, rd);
      if (!wr) chk("R7", $sformatf("read data vec %0d", i), rd, expv);
      chk("R6", $sformatf("frame count vec %0d", i), 32'(total_frames - base), 32'(nb));
      for (int k = 0; k < nb; k++) begin
        chk("R6", $sformatf("frame addr vec %0d byte %0d", i, k),
            {24'b0, fr_addr[(base + k) % 16]}, {24'b0, 8'(a + k)});
        chk("R3", $sformatf("read flag vec %0d byte %0d", i, k),
            {31'b0, fr_rd[(base + k) % 16]}, {31'b0, ~wr});
      end
    end

    // R8: request held during a busy transfer is ignored
    begin
      int base;
      base = total_frames;
      @(negedge clk);
      req_write = 1'b0; req_size = 2'd0; req_addr = 8'h05; req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_write = 1'b1; req_wdata = 32'h0000_00EE; req_size = 2'd2;
      chk("R8", "ready low while busy", {31'b0, req_ready}, 32'd0);
      repeat (100) @(negedge clk);
      chk("R8", "still busy", {31'b0, req_ready}, 32'd0);
      req_valid = 1'b0;
      for (int k = 0; k < 3000 && !done; k++) @(negedge clk);
      chk("R8", "busy read value", rd_data, {24'b0, shadow[5]});
      repeat (300) @(negedge clk);
      chk("R8", "no extra frame", 32'(total_frames - base), 32'd1);
      do_req(1'b0, 2'd2, 8'h05, 32'h0, rd);
      chk("R8", "registers untouched",
          rd, {shadow[5], shadow[6], shadow[7], shadow[8]});
    end

    // R10: clock period
    begin
      int t0, t1, cyc;
      logic pm;
      cyc = 0; t0 = -1; t1 = -1; pm = mdc;
      while (t1 < 0 && cyc < 100) begin
        @(negedge clk);
        cyc++;
        if (mdc && !pm) begin
          if (t0 < 0) t0 = cyc; else t1 = cyc;
        end
        pm = mdc;
      end
      chk("R10", "mdc period", 32'(t1 - t0), 32'(DIV));
    end

    chk("R2", "header errors", 32'(err_hdr), 32'd0);
    chk("R3", "PHY field bit3 errors", 32'(err_phy), 32'd0);
    chk("R4", "write frame errors", 32'(err_wr), 32'd0);
    chk("R5", "read release errors", 32'(err_rd), 32'd0);
    chk("R10", "data edge errors", 32'(err_edge), 32'd0);
    finish_run();
  end
endmodule